// File: doc/BRIEF.md
# Fractal Reshape Address Generator

This block walks the tiles of a matrix result that is held as 16x16 tiles and produces, one per cycle, the addressing for each row segment as it is written out in a re-shaped tile layout. The output type picks the layout. Pass-through keeps 16x16 tiles. The 8-bit merge joins two neighbouring tiles along N into 16x32 tiles. The 4-bit merge joins four of them into 16x64 tiles. The 32-bit split cuts each tile into two 16x8 tiles. A write-side engine takes each segment and moves the 16 (or 8) elements from the source tile position to the destination position. This block only computes where the segments come from and where they go.

A run starts with a `start` pulse while idle. The mode and both dimensions are captured at that moment. A segment is one destination-tile row piece taken from a single source tile. Segments are offered with `seg_valid` and accepted with `seg_ready`. After the last accepted segment, `done` pulses once. A configuration that cannot be laid out is refused: the refusal raises `cfg_err` and no segment is produced.

Top module: `frac_reshape_agen`

## Requirements
- R1: After reset, `seg_valid`, `done` and `cfg_err` are all low.
- R2: With `mode`=0 (pass-through), each destination tile equals its source tile. Each row gives one segment with `dst_col`=0 and `src_col`=0.
- R3: With `mode`=1 (8-bit merge) and N/16 even, source tile columns 2k and 2k+1 fill destination tile column k. Each row gives two segments, with `dst_col` 0 and 16 taken from those two source tiles in that order.
- R4: With `mode`=1 and N/16 odd, the last source tile column becomes a destination tile of its own that is not merged. Its rows give a single segment with `dst_col`=0, and there are (N/16+1)/2 destination tile columns.
- R5: With `mode`=2 (4-bit merge), four consecutive source tile columns fill one destination tile column. Each row gives four segments with `dst_col` 0, 16, 32 and 48.
- R6: With `mode`=3 (32-bit split), source tile column t feeds destination tile columns 2t and 2t+1, with `src_col` 0 and 8 respectively and `dst_col`=0. For M=64 and N=32 this gives 16 destination tiles.
- R7: Segments come out with the segment within a row varying fastest, then the row 0..15, then the destination tile column, then the tile row along M. `src_tile` = tm*(N/16) + source column and `dst_tile` = tm*D + destination column, where D is the number of destination tile columns.
- R8: A start with M or N zero, M or N not a multiple of 16, or mode 2 with N not a multiple of 64, sets `cfg_err` and produces no `seg_valid`. `cfg_err` stays high until the next start that is accepted.
- R9: While `seg_valid` is high and `seg_ready` is low, all segment outputs hold steady. With `seg_ready` held high, one segment is accepted every cycle.
- R10: `done` is high for exactly one cycle, in the cycle after the last segment is accepted, and `seg_valid` is low in that cycle.
- R11: A start during a run is ignored. The mode and dimensions captured at the accepted start govern the whole run, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| mode | input | 2 | 0 pass, 1 merge x2, 2 merge x4, 3 split |
| dim_m | input | DIM_W | Matrix rows M |
| dim_n | input | DIM_W | Matrix columns N |
| seg_ready | input | 1 | Write side accepts the offered segment |
| seg_valid | output | 1 | A segment is offered |
| src_tile | output | 2*(DIM_W-4)+1 | Source tile index |
| dst_tile | output | 2*(DIM_W-4)+1 | Destination tile index |
| seg_row | output | 4 | Row within the tile |
| src_col | output | 4 | Column offset within the source tile |
| dst_col | output | 6 | Column offset within the destination tile |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start was refused |

## Verification
The hardest case to reach is the odd leftover column in 8-bit merge while the write side stalls. There, the per-tile segment count drops from two to one in the middle of a tile row and must step back up at the next tile row. The stimulus runs M=32, N=48 and M=32, N=64 with a ready pattern that drops one cycle in three. It also changes `start`, `mode` and `dim_n` during a run, to show that the captured configuration governs the run. Each accepted segment is compared against a model built from the requirement formulas.

// File: rtl/frac_pkg.sv
package frac_pkg;
    typedef enum logic [1:0] {
        FM_PASS  = 2'd0,
        FM_MRG2  = 2'd1,
        FM_MRG4  = 2'd2,
        FM_SPLIT = 2'd3
    } frac_mode_e;

    localparam int TILE_ROWS = 16;
endpackage

// File: rtl/frac_cfg_decode.sv
module frac_cfg_decode
    import frac_pkg::*;
#(
    parameter int DIM_W = 10,
    localparam int TW = DIM_W - 4
) (
    input  frac_mode_e       mode,
    input  logic [DIM_W-1:0] dim_m,
    input  logic [DIM_W-1:0] dim_n,
    output logic             cfg_ok,
    output logic [TW-1:0]    mt,
    output logic [TW-1:0]    nt,
    output logic [TW:0]      nd,
    output logic [2:0]       segn,
    output logic             tail
);
    logic [TW:0] nt_up;

    always_comb begin
        mt     = dim_m[DIM_W-1:4];
        nt     = dim_n[DIM_W-1:4];
        nt_up  = {1'b0, nt} + {{TW{1'b0}}, 1'b1};
        cfg_ok = (dim_m[3:0] == 4'd0) && (dim_n[3:0] == 4'd0) &&
                 (mt != '0) && (nt != '0);
        tail   = 1'b0;
        nd     = {1'b0, nt};
        segn   = 3'd1;
        case (mode)
            FM_MRG2: begin
                nd   = nt_up >> 1;
                segn = 3'd2;
                tail = nt[0];
            end
            FM_MRG4: begin
                nd     = {3'b000, nt[TW-1:2]};
                segn   = 3'd4;
                cfg_ok = cfg_ok && (nt[1:0] == 2'b00);
            end
            FM_SPLIT: nd = {nt, 1'b0};
            default:  nd = {1'b0, nt};
        endcase
    end
endmodule

// File: rtl/frac_walk.sv
module frac_walk
    import frac_pkg::*;
#(
    parameter int DIM_W = 10,
    localparam int TW = DIM_W - 4,
    localparam int IDX_W = 2 * TW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ready,
    input  logic             cfg_ok,
    input  frac_mode_e       cfg_mode,
    input  logic [TW-1:0]    cfg_mt,
    input  logic [TW-1:0]    cfg_nt,
    input  logic [TW:0]      cfg_nd,
    input  logic [2:0]       cfg_segn,
    input  logic             cfg_tail,
    output logic             busy,
    output logic             done,
    output logic             err,
    output frac_mode_e       cur_mode,
    output logic [TW:0]      cur_dt,
    output logic [3:0]       cur_row,
    output logic [1:0]       cur_seg,
    output logic [IDX_W-1:0] src_base,
    output logic [IDX_W-1:0] dst_base
);
    localparam logic [TW:0]   ND_ONE = {{TW{1'b0}}, 1'b1};
    localparam logic [TW-1:0] MT_ONE = {{(TW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             err;
        frac_mode_e       mode;
        logic [TW-1:0]    mt;
        logic [TW-1:0]    nt;
        logic [TW-1:0]    tm;
        logic [TW:0]      nd;
        logic [TW:0]      dt;
        logic [2:0]       segn;
        logic             tail;
        logic [3:0]       row;
        logic [1:0]       seg;
        logic [IDX_W-1:0] sbase;
        logic [IDX_W-1:0] dbase;
    } walk_t;

    walk_t st_d, st_q;
    logic [2:0] segs_cur;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        segs_cur  = (st_q.tail && (st_q.dt == st_q.nd - ND_ONE)) ? 3'd1 : st_q.segn;
        if (!st_q.busy) begin
            if (start) begin
                if (cfg_ok) begin
                    st_d.busy  = 1'b1;
                    st_d.err   = 1'b0;
                    st_d.mode  = cfg_mode;
                    st_d.mt    = cfg_mt;
                    st_d.nt    = cfg_nt;
                    st_d.nd    = cfg_nd;
                    st_d.segn  = cfg_segn;
                    st_d.tail  = cfg_tail;
                    st_d.tm    = '0;
                    st_d.dt    = '0;
                    st_d.row   = '0;
                    st_d.seg   = '0;
                    st_d.sbase = '0;
                    st_d.dbase = '0;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end else if (ready) begin
            if ({1'b0, st_q.seg} != segs_cur - 3'd1) begin
                st_d.seg = st_q.seg + 2'd1;
            end else begin
                st_d.seg = '0;
                if (st_q.row != 4'd15) begin
                    st_d.row = st_q.row + 4'd1;
                end else begin
                    st_d.row = '0;
                    if (st_q.dt != st_q.nd - ND_ONE) begin
                        st_d.dt = st_q.dt + ND_ONE;
                    end else begin
                        st_d.dt = '0;
                        if (st_q.tm != st_q.mt - MT_ONE) begin
                            st_d.tm    = st_q.tm + MT_ONE;
                            st_d.sbase = st_q.sbase + IDX_W'(st_q.nt);
                            st_d.dbase = st_q.dbase + IDX_W'(st_q.nd);
                        end else begin
                            st_d.busy = 1'b0;
                            st_d.done = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign cur_mode = st_q.mode;
    assign cur_dt   = st_q.dt;
    assign cur_row  = st_q.row;
    assign cur_seg  = st_q.seg;
    assign src_base = st_q.sbase;
    assign dst_base = st_q.dbase;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R10
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy))); // R10
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.busy); // R8
    AST_SEG_IN_TILE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ({1'b0, st_q.seg} < segs_cur)); // R4
endmodule

// File: rtl/frac_map.sv
module frac_map
    import frac_pkg::*;
#(
    parameter int DIM_W = 10,
    localparam int TW = DIM_W - 4,
    localparam int IDX_W = 2 * TW + 1
) (
    input  frac_mode_e       mode,
    input  logic [TW:0]      dt,
    input  logic [1:0]       seg,
    input  logic [IDX_W-1:0] src_base,
    input  logic [IDX_W-1:0] dst_base,
    output logic [IDX_W-1:0] src_tile,
    output logic [IDX_W-1:0] dst_tile,
    output logic [3:0]       src_col,
    output logic [5:0]       dst_col
);
    logic [IDX_W-1:0] tn;

    always_comb begin
        case (mode)
            FM_MRG2:  tn = IDX_W'({dt, 1'b0}) + IDX_W'(seg);
            FM_MRG4:  tn = IDX_W'({dt, 2'b00}) + IDX_W'(seg);
            FM_SPLIT: tn = IDX_W'(dt >> 1);
            default:  tn = IDX_W'(dt);
        endcase
        src_col  = (mode == FM_SPLIT && dt[0]) ? 4'd8 : 4'd0;
        dst_col  = (mode == FM_MRG2 || mode == FM_MRG4) ? {seg, 4'b0000} : 6'd0;
        src_tile = src_base + tn;
        dst_tile = dst_base + IDX_W'(dt);
    end
endmodule

// File: rtl/frac_reshape_agen.sv
module frac_reshape_agen
    import frac_pkg::*;
#(
    parameter int DIM_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mode,
    input  logic [DIM_W-1:0]      dim_m,
    input  logic [DIM_W-1:0]      dim_n,
    input  logic                  seg_ready,
    output logic                  seg_valid,
    output logic [2*(DIM_W-4):0]  src_tile,
    output logic [2*(DIM_W-4):0]  dst_tile,
    output logic [3:0]            seg_row,
    output logic [3:0]            src_col,
    output logic [5:0]            dst_col,
    output logic                  done,
    output logic                  cfg_err
);
    localparam int TW    = DIM_W - 4;
    localparam int IDX_W = 2 * TW + 1;

    logic             cfg_ok, cfg_tail;
    logic [TW-1:0]    cfg_mt, cfg_nt;
    logic [TW:0]      cfg_nd;
    logic [2:0]       cfg_segn;
    frac_mode_e       cur_mode;
    logic [TW:0]      cur_dt;
    logic [1:0]       cur_seg;
    logic [IDX_W-1:0] sbase, dbase;

    frac_cfg_decode #(.DIM_W(DIM_W)) u_dec (
        .mode   (frac_mode_e'(mode)),
        .dim_m  (dim_m),
        .dim_n  (dim_n),
        .cfg_ok (cfg_ok),
        .mt     (cfg_mt),
        .nt     (cfg_nt),
        .nd     (cfg_nd),
        .segn   (cfg_segn),
        .tail   (cfg_tail)
    );

    frac_walk #(.DIM_W(DIM_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ready    (seg_ready),
        .cfg_ok   (cfg_ok),
        .cfg_mode (frac_mode_e'(mode)),
        .cfg_mt   (cfg_mt),
        .cfg_nt   (cfg_nt),
        .cfg_nd   (cfg_nd),
        .cfg_segn (cfg_segn),
        .cfg_tail (cfg_tail),
        .busy     (seg_valid),
        .done     (done),
        .err      (cfg_err),
        .cur_mode (cur_mode),
        .cur_dt   (cur_dt),
        .cur_row  (seg_row),
        .cur_seg  (cur_seg),
        .src_base (sbase),
        .dst_base (dbase)
    );

    frac_map #(.DIM_W(DIM_W)) u_map (
        .mode     (cur_mode),
        .dt       (cur_dt),
        .seg      (cur_seg),
        .src_base (sbase),
        .dst_base (dbase),
        .src_tile (src_tile),
        .dst_tile (dst_tile),
        .src_col  (src_col),
        .dst_col  (dst_col)
    );

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(src_tile) &&
        $stable(dst_tile) && $stable(seg_row) && $stable(src_col) && $stable(dst_col))); // R9
    AST_NO_VALID_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !seg_valid); // R8
    AST_SPLIT_DST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && cur_mode == FM_SPLIT) |-> (dst_col == 6'd0)); // R6
    AST_PASS_SAME_TILE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && cur_mode == FM_PASS) |-> (src_tile == dst_tile)); // R2
endmodule

// File: tb/frac_reshape_agen_tb.sv
module frac_reshape_agen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIM_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [DIM_W-1:0] dim_m = '0;
    logic [DIM_W-1:0] dim_n = '0;
    logic seg_ready = 1'b0;
    logic seg_valid, done, cfg_err;
    logic [2*(DIM_W-4):0] src_tile, dst_tile;
    logic [3:0] seg_row, src_col;
    logic [5:0] dst_col;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    frac_reshape_agen #(.DIM_W(DIM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dim_m(dim_m), .dim_n(dim_n), .seg_ready(seg_ready),
        .seg_valid(seg_valid), .src_tile(src_tile), .dst_tile(dst_tile),
        .seg_row(seg_row), .src_col(src_col), .dst_col(dst_col),
        .done(done), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic run_case(input int md, input int m, input int n, input bit slow,
                            input bit poke, input string tag);
        int nt, mt, nd, segs, tn, cnt, waited, maxdst, fast_stalls;
        bit hv;
        int h_src, h_dst, h_row, h_sc, h_dc;
        nt = n / 16; mt = m / 16;
        case (md)
            1: nd = (nt + 1) / 2;
            2: nd = nt / 4;
            3: nd = nt * 2;
            default: nd = nt;
        endcase
        cnt = 0; maxdst = -1; hv = 0; fast_stalls = 0;
        h_src = 0; h_dst = 0; h_row = 0; h_sc = 0; h_dc = 0;
        @(negedge clk);
        mode = 2'(md); dim_m = DIM_W'(m); dim_n = DIM_W'(n); start = 1'b1;
        for (int tm = 0; tm < mt; tm++) begin
            for (int dt = 0; dt < nd; dt++) begin
                if (md == 1) segs = (nt % 2 == 1 && dt == nd - 1) ? 1 : 2;
                else if (md == 2) segs = 4;
                else segs = 1;
                for (int r = 0; r < 16; r++) begin
                    for (int s = 0; s < segs; s++) begin
                        waited = 0;
                        forever begin
                            @(negedge clk);
                            start = 1'b0;
                            if (poke && cnt == 3) begin
                                start = 1'b1; mode = 2'd2; dim_n = DIM_W'(40);
                            end
                            seg_ready = slow ? (cyc % 3 != 1) : 1'b1;
                            #1;
                            if (cnt == 0 && waited == 0)
                                chk(cfg_err == 1'b0, "R8 err cleared by accepted start", int'(cfg_err), 0);
                            if (hv) begin
                                chk(seg_valid && int'(src_tile) == h_src && int'(dst_tile) == h_dst &&
                                    int'(seg_row) == h_row && int'(src_col) == h_sc && int'(dst_col) == h_dc,
                                    "R9 outputs held while stalled", int'(dst_tile), h_dst);
                            end
                            hv = seg_valid && !seg_ready;
                            h_src = int'(src_tile); h_dst = int'(dst_tile); h_row = int'(seg_row);
                            h_sc = int'(src_col); h_dc = int'(dst_col);
                            if (seg_valid && seg_ready) break;
                            waited++;
                            if (waited > 50) begin
                                chk(1'b0, {tag, " R7 segment never offered"}, cnt, cnt + 1);
                                return;
                            end
                        end
                        if (!slow && cnt > 0 && waited != 0) fast_stalls++;
                        if (md == 1) tn = 2 * dt + s;
                        else if (md == 2) tn = 4 * dt + s;
                        else if (md == 3) tn = dt / 2;
                        else tn = dt;
                        chk(int'(src_tile) == tm * nt + tn, {tag, " R7 src_tile"}, int'(src_tile), tm * nt + tn);
                        chk(int'(dst_tile) == tm * nd + dt, {tag, " R7 dst_tile"}, int'(dst_tile), tm * nd + dt);
                        chk(int'(seg_row) == r, {tag, " R7 row"}, int'(seg_row), r);
                        chk(int'(src_col) == ((md == 3) ? (dt % 2) * 8 : 0), {tag, " src_col"},
                            int'(src_col), (md == 3) ? (dt % 2) * 8 : 0);
                        chk(int'(dst_col) == ((md == 1 || md == 2) ? s * 16 : 0), {tag, " dst_col"},
                            int'(dst_col), (md == 1 || md == 2) ? s * 16 : 0);
                        if (int'(dst_tile) > maxdst) maxdst = int'(dst_tile);
                        cnt++;
                    end
                end
            end
        end
        @(negedge clk);
        start = 1'b0; seg_ready = 1'b1;
        #1;
        chk(done && !seg_valid, {tag, " R10 done after last segment"}, int'(done), 1);
        @(negedge clk);
        #1;
        chk(!done, {tag, " R10 done lasts one cycle"}, int'(done), 0);
        if (!slow) chk(fast_stalls == 0, {tag, " R9 one segment per cycle"}, fast_stalls, 0);
        if (md == 3 && m == 64 && n == 32)
            chk(maxdst + 1 == 16, "R6 split 64x32 yields 16 tiles", maxdst + 1, 16);
        if (md == 1 && nt % 2 == 1)
            chk(maxdst + 1 == mt * ((nt + 1) / 2), "R4 tile count with leftover", maxdst + 1, mt * ((nt + 1) / 2));
    endtask

    task automatic run_err(input int md, input int m, input int n, input string tag);
        int seen;
        seen = 0;
        @(negedge clk);
        mode = 2'(md); dim_m = DIM_W'(m); dim_n = DIM_W'(n); start = 1'b1; seg_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(cfg_err == 1'b1, {tag, " R8 err raised"}, int'(cfg_err), 1);
        for (int i = 0; i < 5; i++) begin
            if (seg_valid) seen++;
            @(negedge clk);
            #1;
        end
        chk(seen == 0 && !seg_valid, {tag, " R8 no segment after refusal"}, seen, 0);
        chk(cfg_err == 1'b1, {tag, " R8 err held"}, int'(cfg_err), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!seg_valid && !done && !cfg_err, "R1 reset state", int'({seg_valid, done, cfg_err}), 0);
        rst_n = 1'b1;
        run_err(0, 40, 32, "pass M not aligned");
        run_case(0, 32, 48, 1'b0, 1'b0, "R2 pass");
        run_case(1, 32, 64, 1'b1, 1'b1, "R3 R11 merge2 even");
        run_case(1, 32, 48, 1'b1, 1'b0, "R4 merge2 odd");
        run_case(1, 16, 16, 1'b0, 1'b0, "R4 merge2 single");
        run_case(2, 16, 128, 1'b0, 1'b0, "R5 merge4");
        run_case(3, 64, 32, 1'b1, 1'b0, "R6 split");
        run_err(2, 32, 96, "merge4 N not x64");
        run_err(1, 0, 32, "M zero");
        run_err(3, 32, 24, "N not aligned");
        run_case(3, 16, 16, 1'b0, 1'b0, "R6 split single");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule